// File: doc/BRIEF.md
# Synonym-Based Speculative Load Value Unit

This unit lets a load obtain its value before its address is known. It replaces the address as the meeting point of producer and consumer with a small tag, called a synonym, that belongs to the instruction addresses (PCs) of both. A small direct-mapped table, indexed by low address bits, remembers the most recent memory instruction that touched each address. When an executed load finds an earlier store or load at the same full address under a different PC, the two PCs form a producer/consumer pair and both are given the same synonym in a PC-indexed predictor. Synonyms come from a wrapping counter. If one PC of the pair already has a synonym, the other PC takes it and no new synonym is allocated.

Whenever an executed memory operation has a synonym, its value goes into that synonym's slot in a value file, and the slot is marked full. When an issued operation (PC only) finds a synonym whose slot is full, the unit returns that value as a speculative result one cycle later. The pipeline carries that value to execution. When the load executes with its real value, the unit reports whether the two values agree. On disagreement it drops the load PC's prediction.

Top module: `cloak_unit`

## Requirements
- R1: After reset no prediction exists: specValid and vfyValid are 0, and an issue of any PC yields specValid = 0.
- R2: After a store at PC S and a later load at PC L (L != S) to the same full address, each later execution of S writes its data into the synonym slot. An issue of L at cycle t then drives specValid = 1 at t+1, with specData equal to the most recent data executed by S.
- R3: A load can act as the producer. A load at PC P followed by a load at PC C to the same address links the two PCs, and C later receives speculatively the value from P's latest execution.
- R4: A freshly allocated synonym starts empty. A consumer issued before any producer has written the slot gets specValid = 0.
- R5: When the producer PC already has a synonym, a newly linked consumer adopts it. A third load that pairs with an already linked load receives values written by the original store PC.
- R6: When only the consumer PC has a synonym, the producer PC adopts it. That producer's later executions then feed the consumer's speculative value.
- R7: An executed load whose speculative-use flag (exSpecUsed) is 1 gives vfyValid = 1 for exactly one cycle, one cycle later. vfyOk is 1 when exData equals exSpecData over all bits and 0 otherwise. A load with the flag at 0 gives no verify pulse.
- R8: A verify mismatch removes the load PC's prediction. Later issues of that PC give specValid = 0 even though its former synonym slot is full.
- R9: When a verify mismatch and a new pair detection fall on the same executed load, the removal wins. No link is made in that cycle, and the PC stays without a prediction.
- R10: No pair forms when the detection entry holds a different address that maps to the same index, when the later operation is a store, or when the recorded PC equals the load's own PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exValid | input | 1 | An executed memory operation is presented |
| exIsStore | input | 1 | Executed operation is a store (1) or a load (0) |
| exPc | input | PC_W | PC of the executed operation |
| exAddr | input | ADDR_W | Memory address of the executed operation |
| exData | input | DATA_W | Real data stored or loaded |
| exSpecUsed | input | 1 | Executed load consumed a speculative value |
| exSpecData | input | DATA_W | Speculative value that load consumed |
| isValid | input | 1 | An issued memory operation is presented |
| isPc | input | PC_W | PC of the issued operation |
| specValid | output | 1 | Speculative value available (one cycle after issue) |
| specData | output | DATA_W | Speculative value |
| vfyValid | output | 1 | Verify result valid (one cycle after executed load) |
| vfyOk | output | 1 | Speculative and real values matched |

## Verification
On a single executed load, two functions can fall in the same cycle: the verify of an earlier speculation and the detection of a fresh producer pair. The bench provokes this by putting a new store PC in front of an already linked load's address. It then executes that load with a wrong speculative value. The outcome is judged at the ports: a mismatch verify pulse, then a later issue of the load PC returns no speculative value, which shows that the removal beat the link.

// File: rtl/cloak_pkg.sv
package cloak_pkg;
  typedef struct packed {
    logic prodWrite;
    logic linkCons;
    logic linkProd;
    logic allocNew;
    logic clearCons;
    logic specFire;
    logic vfyFire;
  } cloak_strobe_t;
endpackage

// File: rtl/cloak_ctl.sv
module cloak_ctl
  import cloak_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exValid,
  input  logic          exIsStore,
  input  logic          exSpecUsed,
  input  logic          isValid,
  input  logic          exPredHit,
  input  logic          prodPredHit,
  input  logic          detHit,
  input  logic          pcSame,
  input  logic          isReady,
  input  logic          dataMatch,
  output cloak_strobe_t strobe
);
  logic isLoad, pairSeen, mismatch;

  always_comb begin
    isLoad   = exValid && !exIsStore;
    pairSeen = isLoad && detHit && !pcSame;
    mismatch = isLoad && exSpecUsed && !dataMatch;

    strobe           = '0;
    strobe.prodWrite = exValid && exPredHit;
    strobe.clearCons = mismatch;
    strobe.linkCons  = pairSeen && !mismatch && prodPredHit;
    strobe.linkProd  = pairSeen && !mismatch && !prodPredHit && exPredHit;
    strobe.allocNew  = pairSeen && !mismatch && !prodPredHit && !exPredHit;
    strobe.specFire  = isValid && isReady;
    strobe.vfyFire   = isLoad && exSpecUsed;
  end

  // R5 R6: at most one way of linking per cycle
  p_single_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.linkCons, strobe.linkProd, strobe.allocNew}));

  // R9: removal of a prediction excludes any link in the same cycle
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearCons |-> !(strobe.linkCons || strobe.linkProd || strobe.allocNew));

  // R10: a store never becomes a consumer
  p_store_no_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exValid && exIsStore) |-> !(strobe.linkCons || strobe.linkProd || strobe.allocNew));
endmodule

// File: rtl/cloak_dp.sv
module cloak_dp
  import cloak_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int PRED_IDX_W = 4,
  parameter int DET_IDX_W  = 3,
  parameter int SYN_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exValid,
  input  logic [PC_W-1:0]   exPc,
  input  logic [ADDR_W-1:0] exAddr,
  input  logic [DATA_W-1:0] exData,
  input  logic [DATA_W-1:0] exSpecData,
  input  logic [PC_W-1:0]   isPc,
  input  cloak_strobe_t     strobe,
  output logic              exPredHit,
  output logic              prodPredHit,
  output logic              detHit,
  output logic              pcSame,
  output logic              isReady,
  output logic              dataMatch,
  output logic              specValid,
  output logic [DATA_W-1:0] specData,
  output logic              vfyValid,
  output logic              vfyOk
);
  localparam int PRED_N = 1 << PRED_IDX_W;
  localparam int DET_N  = 1 << DET_IDX_W;
  localparam int SYN_N  = 1 << SYN_W;

  // PC-indexed predictor
  logic              predV   [PRED_N];
  logic [PC_W-1:0]   predTag [PRED_N];
  logic [SYN_W-1:0]  predSyn [PRED_N];
  // address-indexed detection table
  logic              detV    [DET_N];
  logic [ADDR_W-1:0] detAddr [DET_N];
  logic [PC_W-1:0]   detPc   [DET_N];
  // synonym value file
  logic [SYN_N-1:0]  synFull;
  logic [DATA_W-1:0] synData [SYN_N];
  logic [SYN_W-1:0]  allocCnt;

  logic [PRED_IDX_W-1:0] exIdx, prodIdx, isIdx;
  logic [DET_IDX_W-1:0]  detIdx;
  logic [PC_W-1:0]       prevPc;
  logic [SYN_W-1:0]      exSyn, prodSyn, isSyn;
  logic                  isPredHit;

  always_comb begin
    exIdx       = exPc[PRED_IDX_W-1:0];
    exPredHit   = predV[exIdx] && (predTag[exIdx] == exPc);
    exSyn       = predSyn[exIdx];
    detIdx      = exAddr[DET_IDX_W-1:0];
    detHit      = detV[detIdx] && (detAddr[detIdx] == exAddr);
    prevPc      = detPc[detIdx];
    pcSame      = (prevPc == exPc);
    prodIdx     = prevPc[PRED_IDX_W-1:0];
    prodPredHit = predV[prodIdx] && (predTag[prodIdx] == prevPc);
    prodSyn     = predSyn[prodIdx];
    isIdx       = isPc[PRED_IDX_W-1:0];
    isPredHit   = predV[isIdx] && (predTag[isIdx] == isPc);
    isSyn       = predSyn[isIdx];
    isReady     = isPredHit && synFull[isSyn];
    dataMatch   = (exData == exSpecData);
  end

  // predictor updates: producer entry written before consumer entry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PRED_N; i++) predV[i] <= 1'b0;
    end else begin
      if (strobe.linkProd || strobe.allocNew) begin
        predV[prodIdx]   <= 1'b1;
        predTag[prodIdx] <= prevPc;
        predSyn[prodIdx] <= strobe.allocNew ? allocCnt : exSyn;
      end
      if (strobe.linkCons || strobe.allocNew) begin
        predV[exIdx]   <= 1'b1;
        predTag[exIdx] <= exPc;
        predSyn[exIdx] <= strobe.allocNew ? allocCnt : prodSyn;
      end
      if (strobe.clearCons && exPredHit) predV[exIdx] <= 1'b0;
    end
  end

  // detection table: newest operation on an index replaces the older one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DET_N; i++) detV[i] <= 1'b0;
    end else if (exValid) begin
      detV[detIdx]    <= 1'b1;
      detAddr[detIdx] <= exAddr;
      detPc[detIdx]   <= exPc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               allocCnt <= '0;
    else if (strobe.allocNew) allocCnt <= allocCnt + 1'b1;
  end

  // one slot per synonym
  for (genvar g = 0; g < SYN_N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        synFull[g] <= 1'b0;
      end else if (strobe.allocNew && (allocCnt == SYN_W'(g))) begin
        synFull[g] <= 1'b0;
      end else if (strobe.prodWrite && (exSyn == SYN_W'(g))) begin
        synFull[g] <= 1'b1;
        synData[g] <= exData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      specValid <= 1'b0;
      specData  <= '0;
      vfyValid  <= 1'b0;
      vfyOk     <= 1'b0;
    end else begin
      specValid <= strobe.specFire;
      specData  <= synData[isSyn];
      vfyValid  <= strobe.vfyFire;
      vfyOk     <= dataMatch;
    end
  end

  // R4: each allocation advances the synonym counter by exactly one
  p_alloc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.allocNew |=> (allocCnt == $past(allocCnt) + 1'b1));
endmodule

// File: rtl/cloak_unit.sv
module cloak_unit
  import cloak_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int PRED_IDX_W = 4,
  parameter int DET_IDX_W  = 3,
  parameter int SYN_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exValid,
  input  logic              exIsStore,
  input  logic [PC_W-1:0]   exPc,
  input  logic [ADDR_W-1:0] exAddr,
  input  logic [DATA_W-1:0] exData,
  input  logic              exSpecUsed,
  input  logic [DATA_W-1:0] exSpecData,
  input  logic              isValid,
  input  logic [PC_W-1:0]   isPc,
  output logic              specValid,
  output logic [DATA_W-1:0] specData,
  output logic              vfyValid,
  output logic              vfyOk
);
  cloak_strobe_t strobe;
  logic exPredHit, prodPredHit, detHit, pcSame, isReady, dataMatch;

  cloak_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .exValid(exValid), .exIsStore(exIsStore), .exSpecUsed(exSpecUsed),
    .isValid(isValid), .exPredHit(exPredHit), .prodPredHit(prodPredHit),
    .detHit(detHit), .pcSame(pcSame), .isReady(isReady),
    .dataMatch(dataMatch), .strobe(strobe)
  );

  cloak_dp #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PRED_IDX_W(PRED_IDX_W), .DET_IDX_W(DET_IDX_W), .SYN_W(SYN_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .exValid(exValid), .exPc(exPc), .exAddr(exAddr), .exData(exData),
    .exSpecData(exSpecData), .isPc(isPc), .strobe(strobe),
    .exPredHit(exPredHit), .prodPredHit(prodPredHit), .detHit(detHit),
    .pcSame(pcSame), .isReady(isReady), .dataMatch(dataMatch),
    .specValid(specValid), .specData(specData),
    .vfyValid(vfyValid), .vfyOk(vfyOk)
  );

  // R2: a speculative value only follows an issue
  p_spec_after_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    specValid |-> $past(isValid));

  // R7: a verify pulse only follows an executed load that used a speculative value
  p_vfy_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vfyValid |-> $past(exValid && !exIsStore && exSpecUsed));
endmodule

// File: tb/sim_cloak_unit.sv
module sim_cloak_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16, ADDR_W = 16, DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exValid = 1'b0, exIsStore = 1'b0, exSpecUsed = 1'b0, isValid = 1'b0;
  logic [PC_W-1:0]   exPc = '0, isPc = '0;
  logic [ADDR_W-1:0] exAddr = '0;
  logic [DATA_W-1:0] exData = '0, exSpecData = '0;
  logic specValid, vfyValid, vfyOk;
  logic [DATA_W-1:0] specData;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cloak_unit u0 (
    .clk(clk), .rst_n(rst_n), .exValid(exValid), .exIsStore(exIsStore),
    .exPc(exPc), .exAddr(exAddr), .exData(exData), .exSpecUsed(exSpecUsed),
    .exSpecData(exSpecData), .isValid(isValid), .isPc(isPc),
    .specValid(specValid), .specData(specData), .vfyValid(vfyValid), .vfyOk(vfyOk)
  );

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic execOp(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] addr,
                        input logic [DATA_W-1:0] data, input bit store,
                        input bit used, input logic [DATA_W-1:0] sdata);
    exValid = 1'b1; exPc = pc; exAddr = addr; exData = data;
    exIsStore = store; exSpecUsed = used; exSpecData = sdata;
    @(negedge clk);
    exValid = 1'b0; exSpecUsed = 1'b0;
  endtask

  task automatic issueOp(input logic [PC_W-1:0] pc);
    isValid = 1'b1; isPc = pc;
    @(negedge clk);
    isValid = 1'b0;
  endtask

  task automatic expectSpec(input string req, input bit v, input logic [DATA_W-1:0] d);
    check(specValid == v, req, {31'b0, specValid}, {31'b0, v});
    if (v) check(specData == d, req, specData, d);
  endtask

  task automatic testReset();
    check(specValid == 1'b0, "R1 specValid", {31'b0, specValid}, 0);
    check(vfyValid == 1'b0, "R1 vfyValid", {31'b0, vfyValid}, 0);
    issueOp(16'h0111);
    expectSpec("R1 issue after reset", 1'b0, 0);
  endtask

  task automatic testStoreLoad();
    execOp(16'h0021, 16'h1000, 32'hAAAA0001, 1, 0, 0);
    execOp(16'h0022, 16'h1000, 32'hAAAA0001, 0, 0, 0);
    check(vfyValid == 1'b0, "R7 no verify without flag", {31'b0, vfyValid}, 0);
    issueOp(16'h0022);
    expectSpec("R4 empty slot", 1'b0, 0);
    execOp(16'h0021, 16'h1000, 32'hAAAA0002, 1, 0, 0);
    issueOp(16'h0022);
    expectSpec("R2 store to load value", 1'b1, 32'hAAAA0002);
    @(negedge clk);
    expectSpec("R2 one cycle only", 1'b0, 0);
  endtask

  task automatic testLoadLoad();
    execOp(16'h0033, 16'h2001, 32'h00000055, 0, 0, 0);
    execOp(16'h0034, 16'h2001, 32'h00000055, 0, 0, 0);
    execOp(16'h0033, 16'h2001, 32'h00000066, 0, 0, 0);
    issueOp(16'h0034);
    expectSpec("R3 load to load value", 1'b1, 32'h00000066);
  endtask

  task automatic testConsAdopt();
    execOp(16'h0045, 16'h3002, 32'h1, 1, 0, 0);
    execOp(16'h0046, 16'h3002, 32'h1, 0, 0, 0);
    execOp(16'h0047, 16'h3002, 32'h1, 0, 0, 0);
    execOp(16'h0045, 16'h3002, 32'h00007777, 1, 0, 0);
    issueOp(16'h0047);
    expectSpec("R5 consumer adopts", 1'b1, 32'h00007777);
  endtask

  task automatic testProdAdopt();
    execOp(16'h0058, 16'h4003, 32'h2, 1, 0, 0);
    execOp(16'h0059, 16'h4003, 32'h2, 0, 0, 0);
    execOp(16'h005A, 16'h5003, 32'h3, 1, 0, 0);
    execOp(16'h0059, 16'h5003, 32'h3, 0, 0, 0);
    execOp(16'h005A, 16'h5003, 32'h00001234, 1, 0, 0);
    issueOp(16'h0059);
    expectSpec("R6 producer adopts", 1'b1, 32'h00001234);
  endtask

  task automatic testVerify();
    execOp(16'h0022, 16'h1000, 32'hAAAA0002, 0, 1, 32'hAAAA0002);
    check(vfyValid == 1'b1, "R7 verify pulse", {31'b0, vfyValid}, 1);
    check(vfyOk == 1'b1, "R7 verify match", {31'b0, vfyOk}, 1);
    @(negedge clk);
    check(vfyValid == 1'b0, "R7 single pulse", {31'b0, vfyValid}, 0);
    execOp(16'h0022, 16'h1000, 32'hBBBB0000, 0, 1, 32'hAAAA0002);
    check(vfyValid == 1'b1, "R7 verify pulse 2", {31'b0, vfyValid}, 1);
    check(vfyOk == 1'b0, "R7 verify mismatch", {31'b0, vfyOk}, 0);
    issueOp(16'h0022);
    expectSpec("R8 prediction removed", 1'b0, 0);
  endtask

  task automatic testCollision();
    execOp(16'h006B, 16'h6004, 32'h5, 1, 0, 0);
    execOp(16'h006C, 16'h6004, 32'h5, 0, 0, 0);
    execOp(16'h006B, 16'h6004, 32'h00000099, 1, 0, 0);
    issueOp(16'h006C);
    expectSpec("R9 setup link", 1'b1, 32'h00000099);
    execOp(16'h006D, 16'h6004, 32'h00000042, 1, 0, 0);
    execOp(16'h006C, 16'h6004, 32'h00000042, 0, 1, 32'h00000099);
    check(vfyValid == 1'b1 && vfyOk == 1'b0, "R9 mismatch reported",
          {30'b0, vfyValid, vfyOk}, 32'h2);
    issueOp(16'h006C);
    expectSpec("R9 removal wins over link", 1'b0, 0);
  endtask

  task automatic testNoPair();
    execOp(16'h007E, 16'h7005, 32'h7, 1, 0, 0);
    execOp(16'h007F, 16'h700D, 32'h7, 0, 0, 0);
    execOp(16'h007E, 16'h7005, 32'h8, 1, 0, 0);
    issueOp(16'h007F);
    expectSpec("R10 aliased address", 1'b0, 0);
    execOp(16'h0081, 16'h8006, 32'h9, 1, 0, 0);
    execOp(16'h0082, 16'h8006, 32'h9, 1, 0, 0);
    execOp(16'h0081, 16'h8006, 32'hA, 1, 0, 0);
    issueOp(16'h0082);
    expectSpec("R10 store is no consumer", 1'b0, 0);
    execOp(16'h0083, 16'h9007, 32'hB, 0, 0, 0);
    execOp(16'h0083, 16'h9007, 32'hB, 0, 0, 0);
    execOp(16'h0083, 16'h9007, 32'hC, 0, 0, 0);
    issueOp(16'h0083);
    expectSpec("R10 no self pair", 1'b0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testStoreLoad();
    testLoadLoad();
    testConsAdopt();
    testProdAdopt();
    testVerify();
    testCollision();
    testNoPair();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule